// File: doc/BRIEF.md
# Real-Mode Segment Address Generator

This block is the real-mode address path of an x86-style core. It keeps six segment registers, each made of a visible 16-bit selector and a hidden base that sits beside it. Every linear address it produces is a hidden base plus a 16-bit offset. Code fetches use the code segment and the instruction pointer. Data requests name a segment and supply an offset.

Because the hidden base is stored apart from the selector, the state after reset can be inconsistent on purpose. The code selector reads F000h while its base is FFFF_0000h, so the first fetch lands 16 bytes below the top of the 4 GB space. The first write to the code selector replaces that base with the selector shifted left by four bits. From then on, fetches stay inside the first megabyte until the next reset.

The block also holds the reset image of the flags and control registers, so the rest of the core can read a consistent power-up state. All outputs are registered. A synchronous active-high reset restores the whole state.

Top module: `rmseg_addr_gen`

## Requirements
- R1: Segment indices are encoded 0=ES, 1=CS, 2=SS, 3=DS, 4=FS, 5=GS. Selector i appears on `sel_flat[16*i+15:16*i]`. After reset, CS reads F000h and the other five selectors read 0000h.
- R2: After reset, the hidden CS base is FFFF_0000h and the other five bases are zero. A data request on CS at offset X therefore yields FFFF_0000h+X, and a request on any other segment yields X.
- R3: After reset, `ip_o` is 0000_FFF0h and `fetch_addr` is FFFF_FFF0h in the first cycle after reset is released.
- R4: `fetch_addr` is the CS hidden base plus IP[15:0], formed from the state before each clock edge. `data_addr` is the requested segment's base plus `req_off`, valid with `data_vld` one cycle after `req_vld`.
- R5: A selector load with an index from 0 to 5 updates that selector and sets its base to the value shifted left by 4, at the same clock edge. Requests in the following cycles use the new base.
- R6: Once CS has been loaded, `fetch_addr[31:20]` stays zero until the next reset.
- R7: A sum of base and offset wraps to 20 bits for any base written by a load. The untouched post-reset CS base keeps its upper bits, so its sums are full 32-bit values.
- R8: A selector load with index 6 or 7 changes no selector and no base. A request with segment index 6 or 7 leaves `data_vld` low.
- R9: When a selector load and a data request on the same segment fall in the same cycle, the request uses the base from before the load.
- R10: `ip_ld` loads `ip_val` zero-extended and takes priority over `ip_inc`. `ip_inc` adds `ip_step` modulo 2^16.
- R11: `eflags_o` reads 0000_0002h and `cr0_o` reads 6000_0010h (paging bit 31 and protection-enable bit 0 both clear). `cr2_o`, `cr3_o` and `cr4_o` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_ld | input | 1 | Selector load strobe |
| sel_idx | input | 3 | Segment index for the load |
| sel_val | input | 16 | Selector value to load |
| ip_ld | input | 1 | Instruction pointer load |
| ip_val | input | 16 | Instruction pointer value |
| ip_inc | input | 1 | Instruction pointer advance |
| ip_step | input | 4 | Advance amount |
| req_vld | input | 1 | Data address request |
| req_seg | input | 3 | Segment index of the request |
| req_off | input | 16 | Effective offset of the request |
| fetch_addr | output | 32 | Registered linear fetch address |
| data_vld | output | 1 | Data address valid |
| data_addr | output | 32 | Registered linear data address |
| sel_flat | output | 96 | All six visible selectors |
| ip_o | output | 32 | Instruction pointer |
| eflags_o | output | 32 | Flags reset image |
| cr0_o | output | 32 | CR0 reset image |
| cr2_o | output | 32 | CR2 reset image |
| cr3_o | output | 32 | CR3 reset image |
| cr4_o | output | 32 | CR4 reset image |

## Verification
Two functions can fall in the same cycle. A selector load can coincide with a data request that reads the same segment, and a CS load can coincide with the fetch that reads the CS base. The bench provokes the first case by loading DS with FFFFh while it requests DS at offset FFFFh. It expects the old zero base, 0000_FFFFh, and then the wrapped 0000_FFEFh on the following request. It provokes the second case by reloading CS and checking that the fetch one cycle later still carries the old upper bits while the fetch after that is confined. Random phases with loads, requests and IP updates all active at once are compared against a behavioural model on every clock.

// File: rtl/rmseg_pkg.sv
package rmseg_pkg;
  typedef enum logic [2:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_e;

  localparam logic [15:0] CS_RST_SEL  = 16'hF000;
  localparam logic [31:0] CS_RST_BASE = 32'hFFFF_0000;
  localparam logic [31:0] IP_RST      = 32'h0000_FFF0;
  localparam logic [31:0] EFLAGS_RST  = 32'h0000_0002;
  localparam logic [31:0] CR0_RST     = 32'h6000_0010;
endpackage

// File: rtl/rmseg_segfile.sv
module rmseg_segfile #(
  parameter int NSEG   = 6,
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32,
  parameter int SHIFT  = 4,
  parameter int CS_IDX = 1,
  parameter int IDX_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld,
  input  logic [IDX_W-1:0]         ld_idx,
  input  logic [SEL_W-1:0]         ld_val,
  output logic [NSEG*SEL_W-1:0]    sel_flat,
  output logic [NSEG*ADDR_W-1:0]   base_flat,
  output logic [NSEG-1:0]          big
);
  import rmseg_pkg::*;

  localparam int SHIFTED_W = SEL_W + SHIFT;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    localparam logic [SEL_W-1:0]  RST_SEL  = (g == CS_IDX) ? SEL_W'(CS_RST_SEL)   : '0;
    localparam logic [ADDR_W-1:0] RST_BASE = (g == CS_IDX) ? ADDR_W'(CS_RST_BASE) : '0;
    localparam logic              RST_BIG  = (g == CS_IDX);

    logic [SEL_W-1:0]  sel_q;
    logic [ADDR_W-1:0] base_q;
    logic              big_q;
    logic              hit;

    assign hit = ld && (ld_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q  <= RST_SEL;
        base_q <= RST_BASE;
        big_q  <= RST_BIG;
      end else if (hit) begin
        sel_q  <= ld_val;
        base_q <= ADDR_W'({ld_val, {SHIFT{1'b0}}});
        big_q  <= 1'b0;
      end
    end

    assign sel_flat[g*SEL_W +: SEL_W]    = sel_q;
    assign base_flat[g*ADDR_W +: ADDR_W] = base_q;
    assign big[g]                        = big_q;
  end

  localparam int UNUSED_W = SHIFTED_W;
endmodule

// File: rtl/rmseg_agu.sv
module rmseg_agu #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int REAL_W = 20
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              big,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum  = base + ADDR_W'(off);
    addr = big ? sum : {{(ADDR_W-REAL_W){1'b0}}, sum[REAL_W-1:0]};
  end
endmodule

// File: rtl/rmseg_ipctl.sv
module rmseg_ipctl #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ip_ld,
  input  logic [OFF_W-1:0]  ip_val,
  input  logic              ip_inc,
  input  logic [STEP_W-1:0] ip_step,
  output logic [ADDR_W-1:0] ip_q,
  output logic [ADDR_W-1:0] eflags_q,
  output logic [ADDR_W-1:0] cr0_q,
  output logic [ADDR_W-1:0] cr2_q,
  output logic [ADDR_W-1:0] cr3_q,
  output logic [ADDR_W-1:0] cr4_q
);
  import rmseg_pkg::*;

  logic [OFF_W-1:0] ip_next_lo;

  assign ip_next_lo = ip_q[OFF_W-1:0] + OFF_W'(ip_step);

  always_ff @(posedge clk) begin
    if (rst) begin
      ip_q <= ADDR_W'(IP_RST);
    end else if (ip_ld) begin
      ip_q <= ADDR_W'(ip_val);
    end else if (ip_inc) begin
      ip_q <= ADDR_W'(ip_next_lo);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eflags_q <= ADDR_W'(EFLAGS_RST);
      cr0_q    <= ADDR_W'(CR0_RST);
      cr2_q    <= '0;
      cr3_q    <= '0;
      cr4_q    <= '0;
    end
  end
endmodule

// File: rtl/rmseg_addr_gen.sv
module rmseg_addr_gen #(
  parameter int NSEG   = 6,
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int REAL_W = 20,
  parameter int STEP_W = 4,
  parameter int CS_IDX = 1,
  localparam int IDX_W = $clog2(NSEG),
  localparam int SHIFT = REAL_W - SEL_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sel_ld,
  input  logic [IDX_W-1:0]      sel_idx,
  input  logic [SEL_W-1:0]      sel_val,
  input  logic                  ip_ld,
  input  logic [OFF_W-1:0]      ip_val,
  input  logic                  ip_inc,
  input  logic [STEP_W-1:0]     ip_step,
  input  logic                  req_vld,
  input  logic [IDX_W-1:0]      req_seg,
  input  logic [OFF_W-1:0]      req_off,
  output logic [ADDR_W-1:0]     fetch_addr,
  output logic                  data_vld,
  output logic [ADDR_W-1:0]     data_addr,
  output logic [NSEG*SEL_W-1:0] sel_flat,
  output logic [ADDR_W-1:0]     ip_o,
  output logic [ADDR_W-1:0]     eflags_o,
  output logic [ADDR_W-1:0]     cr0_o,
  output logic [ADDR_W-1:0]     cr2_o,
  output logic [ADDR_W-1:0]     cr3_o,
  output logic [ADDR_W-1:0]     cr4_o
);
  import rmseg_pkg::*;

  localparam logic [ADDR_W-1:0] FETCH_RST = ADDR_W'(CS_RST_BASE) + ADDR_W'(IP_RST);

  logic [NSEG*ADDR_W-1:0] base_flat;
  logic [NSEG-1:0]        big;
  logic [ADDR_W-1:0]      d_base;
  logic                   d_big;
  logic                   d_in_range;
  logic [ADDR_W-1:0]      f_lin;
  logic [ADDR_W-1:0]      d_lin;

  rmseg_segfile #(
    .NSEG(NSEG), .SEL_W(SEL_W), .ADDR_W(ADDR_W),
    .SHIFT(SHIFT), .CS_IDX(CS_IDX), .IDX_W(IDX_W)
  ) u_segfile (
    .clk(clk), .rst(rst),
    .ld(sel_ld), .ld_idx(sel_idx), .ld_val(sel_val),
    .sel_flat(sel_flat), .base_flat(base_flat), .big(big)
  );

  rmseg_ipctl #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .STEP_W(STEP_W)
  ) u_ipctl (
    .clk(clk), .rst(rst),
    .ip_ld(ip_ld), .ip_val(ip_val), .ip_inc(ip_inc), .ip_step(ip_step),
    .ip_q(ip_o), .eflags_q(eflags_o), .cr0_q(cr0_o),
    .cr2_q(cr2_o), .cr3_q(cr3_o), .cr4_q(cr4_o)
  );

  always_comb begin
    d_base     = '0;
    d_big      = 1'b0;
    d_in_range = 1'b0;
    for (int i = 0; i < NSEG; i++) begin
      if (req_seg == IDX_W'(i)) begin
        d_base     = base_flat[i*ADDR_W +: ADDR_W];
        d_big      = big[i];
        d_in_range = 1'b1;
      end
    end
  end

  rmseg_agu #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .REAL_W(REAL_W)) u_agu_fetch (
    .base(base_flat[CS_IDX*ADDR_W +: ADDR_W]),
    .big(big[CS_IDX]),
    .off(ip_o[OFF_W-1:0]),
    .addr(f_lin)
  );

  rmseg_agu #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .REAL_W(REAL_W)) u_agu_data (
    .base(d_base), .big(d_big), .off(req_off), .addr(d_lin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_addr <= FETCH_RST;
      data_vld   <= 1'b0;
      data_addr  <= '0;
    end else begin
      fetch_addr <= f_lin;
      data_vld   <= req_vld && d_in_range;
      if (req_vld && d_in_range) begin
        data_addr <= d_lin;
      end
    end
  end
endmodule

// File: rtl/rmseg_addr_gen_chk.sv
module rmseg_addr_gen_chk #(
  parameter int NSEG   = 6,
  parameter int SEL_W  = 16,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int REAL_W = 20,
  parameter int CS_IDX = 1,
  parameter int IDX_W  = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sel_ld,
  input logic [IDX_W-1:0]      sel_idx,
  input logic [SEL_W-1:0]      sel_val,
  input logic                  ip_ld,
  input logic [OFF_W-1:0]      ip_val,
  input logic                  req_vld,
  input logic [IDX_W-1:0]      req_seg,
  input logic [ADDR_W-1:0]     fetch_addr,
  input logic                  data_vld,
  input logic [NSEG*SEL_W-1:0] sel_flat,
  input logic [ADDR_W-1:0]     ip_o
);
  localparam logic [NSEG*SEL_W-1:0] RST_FLAT =
    (NSEG*SEL_W)'(16'hF000) << (CS_IDX*SEL_W);

  logic cs_seen;
  always_ff @(posedge clk) begin
    if (rst) cs_seen <= 1'b0;
    else if (sel_ld && sel_idx == IDX_W'(CS_IDX)) cs_seen <= 1'b1;
  end

  // R1
  reset_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> sel_flat == RST_FLAT);

  // R3
  first_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_addr == 32'hFFFF_FFF0) && (ip_o == 32'h0000_FFF0));

  // R5
  for (genvar g = 0; g < NSEG; g++) begin : g_ld
    sel_load_chk: assert property (@(posedge clk) disable iff (rst)
      (sel_ld && sel_idx == IDX_W'(g)) |=> sel_flat[g*SEL_W +: SEL_W] == $past(sel_val));
  end

  // R6
  cs_confine_chk: assert property (@(posedge clk) disable iff (rst)
    cs_seen |=> fetch_addr[ADDR_W-1:REAL_W] == '0);

  // R8
  bad_idx_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_ld && sel_idx >= IDX_W'(NSEG)) |=> $stable(sel_flat));

  // R8
  bad_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_seg >= IDX_W'(NSEG)) |=> !data_vld);

  // R4
  good_req_chk: assert property (@(posedge clk) disable iff (rst)
    (req_vld && req_seg < IDX_W'(NSEG)) |=> data_vld);

  // R10
  ip_load_chk: assert property (@(posedge clk) disable iff (rst)
    ip_ld |=> ip_o == ADDR_W'($past(ip_val)));
endmodule

bind rmseg_addr_gen rmseg_addr_gen_chk #(
  .NSEG(NSEG), .SEL_W(SEL_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
  .REAL_W(REAL_W), .CS_IDX(CS_IDX), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .sel_ld(sel_ld), .sel_idx(sel_idx), .sel_val(sel_val),
  .ip_ld(ip_ld), .ip_val(ip_val), .req_vld(req_vld), .req_seg(req_seg),
  .fetch_addr(fetch_addr), .data_vld(data_vld), .sel_flat(sel_flat), .ip_o(ip_o)
);

// File: tb/rmseg_addr_gen_bench.sv
module rmseg_addr_gen_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        sel_ld = 0;
  logic [2:0]  sel_idx = 0;
  logic [15:0] sel_val = 0;
  logic        ip_ld = 0;
  logic [15:0] ip_val = 0;
  logic        ip_inc = 0;
  logic [3:0]  ip_step = 0;
  logic        req_vld = 0;
  logic [2:0]  req_seg = 0;
  logic [15:0] req_off = 0;
  logic [31:0] fetch_addr, data_addr, ip_o, eflags_o, cr0_o, cr2_o, cr3_o, cr4_o;
  logic        data_vld;
  logic [95:0] sel_flat;

  rmseg_addr_gen u_rmseg_addr_gen (
    .clk(clk), .rst(rst), .sel_ld(sel_ld), .sel_idx(sel_idx), .sel_val(sel_val),
    .ip_ld(ip_ld), .ip_val(ip_val), .ip_inc(ip_inc), .ip_step(ip_step),
    .req_vld(req_vld), .req_seg(req_seg), .req_off(req_off),
    .fetch_addr(fetch_addr), .data_vld(data_vld), .data_addr(data_addr),
    .sel_flat(sel_flat), .ip_o(ip_o), .eflags_o(eflags_o), .cr0_o(cr0_o),
    .cr2_o(cr2_o), .cr3_o(cr3_o), .cr4_o(cr4_o)
  );

  int checks = 0;
  int errors = 0;
  bit live = 0;

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [15:0] m_sel [6];
  logic [31:0] m_base [6];
  bit          m_big [6];
  logic [31:0] m_ip, m_fetch, m_da;
  bit          m_dv;

  function automatic logic [31:0] lin(int s, logic [15:0] off);
    logic [31:0] sum;
    sum = m_base[s] + {16'h0, off};
    return m_big[s] ? sum : (sum & 32'h000F_FFFF);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) begin
        m_sel[i]  = (i == 1) ? 16'hF000 : 16'h0;
        m_base[i] = (i == 1) ? 32'hFFFF_0000 : 32'h0;
        m_big[i]  = (i == 1);
      end
      m_ip = 32'h0000_FFF0; m_fetch = 32'hFFFF_FFF0; m_dv = 0; m_da = 0;
    end else begin
      m_fetch = lin(1, m_ip[15:0]);
      m_dv = req_vld && (req_seg < 3'd6);
      if (m_dv) m_da = lin(int'(req_seg), req_off);
      if (sel_ld && sel_idx < 3'd6) begin
        m_sel[sel_idx]  = sel_val;
        m_base[sel_idx] = {12'h0, sel_val, 4'h0};
        m_big[sel_idx]  = 0;
      end
      if (ip_ld) m_ip = {16'h0, ip_val};
      else if (ip_inc) m_ip = {16'h0, m_ip[15:0] + {12'h0, ip_step}};
    end
  end

  always @(negedge clk) begin
    if (live && !rst) begin
      for (int i = 0; i < 6; i++) chk("R5 model selector", sel_flat[16*i +: 16], m_sel[i]);
      chk("R4 model fetch_addr", fetch_addr, m_fetch);
      chk("R8 model data_vld", data_vld, m_dv);
      if (m_dv) chk("R4 model data_addr", data_addr, m_da);
      chk("R10 model ip", ip_o, m_ip);
      chk("R11 model eflags", eflags_o, 32'h2);
      chk("R11 model cr0", cr0_o, 32'h6000_0010);
    end
  end

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic clear();
    sel_ld = 0; ip_ld = 0; ip_inc = 0; req_vld = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [95:0] saved;
    repeat (3) @(posedge clk);
    #2 rst = 0; live = 1;

    chk("R1 CS selector", sel_flat[31:16], 16'hF000);
    chk("R1 other selectors", {sel_flat[95:32], sel_flat[15:0]}, 0);
    chk("R3 first fetch", fetch_addr, 32'hFFFF_FFF0);
    chk("R3 ip reset", ip_o, 32'h0000_FFF0);
    chk("R11 eflags", eflags_o, 32'h0000_0002);
    chk("R11 cr0", cr0_o, 32'h6000_0010);
    chk("R11 cr2..4", {cr2_o, cr3_o, cr4_o}, 0);

    req_vld = 1; req_seg = 3'd1; req_off = 16'h1234; cyc(); clear();
    chk("R2 CS base", data_addr, 32'hFFFF_1234);
    chk("R4 data_vld", data_vld, 1);
    req_vld = 1; req_seg = 3'd3; req_off = 16'h0055; cyc(); clear();
    chk("R2 DS base", data_addr, 32'h0000_0055);

    ip_inc = 1; ip_step = 4'd2; cyc(); clear();
    chk("R10 ip inc", ip_o, 32'h0000_FFF2);
    cyc();
    chk("R4 fetch", fetch_addr, 32'hFFFF_FFF2);

    ip_ld = 1; ip_val = 16'hFFFE; cyc(); clear();
    ip_inc = 1; ip_step = 4'd4; cyc(); clear();
    chk("R10 ip wrap", ip_o, 32'h0000_0002);
    cyc();
    chk("R7 reset CS keeps upper", fetch_addr, 32'hFFFF_0002);

    ip_ld = 1; ip_val = 16'h0100; ip_inc = 1; ip_step = 4'd3; cyc(); clear();
    chk("R10 load priority", ip_o, 32'h0000_0100);

    sel_ld = 1; sel_idx = 3'd3; sel_val = 16'hFFFF;
    req_vld = 1; req_seg = 3'd3; req_off = 16'hFFFF; cyc(); clear();
    chk("R9 old base", data_addr, 32'h0000_FFFF);
    chk("R5 DS selector", sel_flat[63:48], 16'hFFFF);
    req_vld = 1; req_seg = 3'd3; req_off = 16'hFFFF; cyc(); clear();
    chk("R7 wrap", data_addr, 32'h0000_FFEF);

    sel_ld = 1; sel_idx = 3'd0; sel_val = 16'h1234; cyc(); clear();
    req_vld = 1; req_seg = 3'd0; req_off = 16'h0005; cyc(); clear();
    chk("R5 ES new base", data_addr, 32'h0001_2345);

    saved = sel_flat;
    sel_ld = 1; sel_idx = 3'd6; sel_val = 16'hAAAA; cyc(); clear();
    chk("R8 index 6 ignored", sel_flat, saved);
    sel_ld = 1; sel_idx = 3'd7; sel_val = 16'h5555; cyc(); clear();
    chk("R8 index 7 ignored", sel_flat, saved);
    req_vld = 1; req_seg = 3'd7; req_off = 16'h0001; cyc(); clear();
    chk("R8 bad request", data_vld, 0);
    req_vld = 1; req_seg = 3'd3; req_off = 16'h0010; cyc(); clear();
    chk("R8 DS base intact", data_addr, 32'h0000_0000);

    sel_ld = 1; sel_idx = 3'd1; sel_val = 16'hF000; cyc(); clear();
    chk("R6 fetch during load old base", fetch_addr, 32'hFFFF_0100);
    cyc();
    chk("R6 confined fetch", fetch_addr, 32'h000F_0100);
    sel_ld = 1; sel_idx = 3'd1; sel_val = 16'hFFFF; cyc(); clear();
    cyc();
    chk("R6 R7 wrapped fetch", fetch_addr, 32'h0000_00F0);

    rst = 1; cyc(); cyc(); rst = 0;
    chk("R3 fetch after second reset", fetch_addr, 32'hFFFF_FFF0);
    req_vld = 1; req_seg = 3'd1; req_off = 16'h0000; cyc(); clear();
    chk("R2 CS base after second reset", data_addr, 32'hFFFF_0000);

    for (int n = 0; n < 400; n++) begin
      sel_ld = ($urandom % 4) == 0; sel_idx = 3'($urandom); sel_val = 16'($urandom);
      ip_ld = ($urandom % 8) == 0; ip_val = 16'($urandom);
      ip_inc = $urandom % 2; ip_step = 4'($urandom);
      req_vld = $urandom % 2; req_seg = 3'($urandom); req_off = 16'($urandom);
      cyc();
    end
    clear();
    cyc();
    finish_run();
  end
endmodule